// File: doc/BRIEF.md
# Day and Seconds Real-Time Clock Core

This block keeps wall time as two binary counts: a count of elapsed days and a count of seconds elapsed within the current day. A low-frequency clock enable (nominally 32768 Hz) drives a prescaler, and each prescaler wrap advances the seconds count by one. Software turns the two counts into calendar time. The block does no date or hour conversion of its own.

The seconds-of-day value is 17 bits wide and is split across two register fields: a low byte and a 9-bit high part. These sit beside a 15-bit day field. Software sets the clock in three steps. It first writes zero to the low field, so that the high field cannot carry for 255 seconds. It then writes the day field and the high field. The final write to the low field starts the new time and restarts the prescaler. Reads see the live counters with no snapshot, so software reads the high field twice to notice a carry.

A set of alarm registers holds a full {day, seconds} value. When the clock reaches that value, a sticky alarm status bit is set. A second sticky bit is set on every seconds tick. Each bit drives an interrupt output through its own enable.

Top module: `rtc_day_sec_core`

## Requirements
- R1: The register map uses word offsets 0 day, 1 seconds low byte, 2 seconds high part, 3 alarm day, 4 alarm seconds low, 5 alarm seconds high, 6 status, 7 interrupt enable. The seconds-of-day value is {high[8:0], low[7:0]}.
- R2: Each seconds tick adds one to the seconds-of-day count. When the count is 86399 or more, the tick sets it to 0 and adds one to the day count.
- R3: The day count is 15 bits wide. It wraps from 0x7FFF to 0.
- R4: A seconds tick occurs on every PRESC_DIV-th cycle that has tick_en high. A write to offset 1 restarts the prescaler, so the next tick needs a full PRESC_DIV enables.
- R5: A write changes only the bits inside its field: 15 bits for day, 8 bits for low, 9 bits for high, and 2 bits for status and enable. Unused bits read as 0. Read data appears in the cycle after bus_rd is sampled.
- R6: Reads return live values. A tick that carries out of the low byte shows the low field at 0 and the high field incremented.
- R7: While the low field is below 0xFF and the day does not end, a tick leaves the high field unchanged. After a write of 0 to the low field, the high field therefore holds for 255 ticks.
- R8: Every seconds tick sets status bit 1, the update bit.
- R9: Status bit 0, the alarm bit, is set when a tick moves the counters to a value whose {day, seconds} equals the alarm registers. A tick that reaches any other value does not set it.
- R10: irq_alarm and irq_tick are registered copies of status bit 0 AND enable bit 0, and of status bit 1 AND enable bit 1. Each follows a change of status or enable one cycle later.
- R11: Status bits are cleared by writing 1 to them at offset 6. Bits written as 0 keep their value.
- R12: Reset clears the counters, the alarm registers, the status bits, the enable bits, the prescaler and both interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Low-frequency clock enable (32768 Hz nominal) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_tick | output | 1 | Once-per-second update interrupt |

## Verification
The assertions assume the following about the inputs:
- Bus address and data are stable for the cycle in which a strobe is high.
- A write to a live counter field in the same cycle as a seconds tick is resolved in favour of the write. The checks on the counter roll-over and the carry are therefore limited to ticks that meet no such write.

The stimulus holds tick_en low during every bus access. As a result, no write coincides with a tick and every read sees counters that are not moving. Seconds are then advanced in whole multiples of the prescaler period, so each expected count is exact.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DAY_W       = 15;
  localparam int LO_W        = 8;
  localparam int HI_W        = 9;
  localparam int SOD_W       = LO_W + HI_W;
  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 3;
  localparam int IRQ_N       = 2;
  localparam int SEC_PER_DAY = 86400;

  typedef enum logic [ADDR_W-1:0] {
    A_DAY  = 3'd0,
    A_TLO  = 3'd1,
    A_THI  = 3'd2,
    A_ADAY = 3'd3,
    A_ALO  = 3'd4,
    A_AHI  = 3'd5,
    A_STAT = 3'd6,
    A_MASK = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [SOD_W-1:0] sod;
  } stamp_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic restart,
  output logic sec_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign sec_tick = tick_en && !restart && (cnt_q == LAST);

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sec_tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DAY_W-1:0]    wdata,
  output stamp_t              now_q,
  output stamp_t              alm_q,
  output logic                alarm_hit
);
  localparam logic [SOD_W-1:0] SOD_LAST = SOD_W'(SEC_PER_DAY - 1);

  logic   live_wr;
  stamp_t nxt;

  assign live_wr = wr_en && (addr == A_DAY || addr == A_TLO || addr == A_THI);

  always_comb begin
    nxt = now_q;
    if (now_q.sod >= SOD_LAST) begin
      nxt.sod = '0;
      nxt.day = now_q.day + 1'b1;
    end else begin
      nxt.sod = now_q.sod + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= '0;
      alm_q <= '0;
    end else begin
      if (live_wr) begin
        case (addr)
          A_DAY:   now_q.day             <= wdata[DAY_W-1:0];
          A_TLO:   now_q.sod[LO_W-1:0]   <= wdata[LO_W-1:0];
          A_THI:   now_q.sod[SOD_W-1:LO_W] <= wdata[HI_W-1:0];
          default: ;
        endcase
      end else if (sec_tick) begin
        now_q <= nxt;
      end
      if (wr_en) begin
        case (addr)
          A_ADAY:  alm_q.day               <= wdata[DAY_W-1:0];
          A_ALO:   alm_q.sod[LO_W-1:0]     <= wdata[LO_W-1:0];
          A_AHI:   alm_q.sod[SOD_W-1:LO_W] <= wdata[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign alarm_hit = sec_tick && !live_wr && (nxt == alm_q);

  assert_day_roll_R2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !live_wr && now_q.sod == SOD_LAST) |=>
      (now_q.sod == '0 && now_q.day == DAY_W'($past(now_q.day) + 1'b1)));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !wr_en) |=> $stable(now_q));
  assert_high_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !live_wr && now_q.sod[LO_W-1:0] != 8'hFF && now_q.sod < SOD_LAST) |=>
      (now_q.sod[SOD_W-1:LO_W] == $past(now_q.sod[SOD_W-1:LO_W])));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             alarm_hit,
  input  logic             sec_tick,
  input  logic             stat_wr,
  input  logic             mask_wr,
  input  logic [IRQ_N-1:0] wdata,
  output logic [IRQ_N-1:0] stat_q,
  output logic [IRQ_N-1:0] mask_q,
  output logic             irq_alarm,
  output logic             irq_tick
);
  logic [IRQ_N-1:0] set_v, clr_v;

  assign set_v = {sec_tick, alarm_hit};
  assign clr_v = stat_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      mask_q    <= '0;
      irq_alarm <= 1'b0;
      irq_tick  <= 1'b0;
    end else begin
      stat_q    <= (stat_q & ~clr_v) | set_v;
      if (mask_wr) mask_q <= wdata;
      irq_alarm <= stat_q[0] & mask_q[0];
      irq_tick  <= stat_q[1] & mask_q[1];
    end
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !(stat_wr && wdata[0])) |=> stat_q[0]);
  assert_tick_status_R8: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> stat_q[1]);
  assert_alarm_status_R9: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> stat_q[0]);
endmodule

// File: rtl/rtc_day_sec_core.sv
module rtc_day_sec_core
  import rtc_pkg::*;
#(
  parameter int PRESC_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);
  logic             sec_tick, alarm_hit, restart;
  stamp_t           now_q, alm_q;
  logic [IRQ_N-1:0] stat_q, mask_q;
  logic [DATA_W-1:0] rd_mux;

  assign restart = bus_wr && (bus_addr == A_TLO);

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst(rst), .tick_en(tick_en), .restart(restart), .sec_tick(sec_tick)
  );

  rtc_time_regs u_time (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[DAY_W-1:0]), .now_q(now_q), .alm_q(alm_q), .alarm_hit(alarm_hit)
  );

  rtc_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .alarm_hit(alarm_hit), .sec_tick(sec_tick),
    .stat_wr(bus_wr && bus_addr == A_STAT), .mask_wr(bus_wr && bus_addr == A_MASK),
    .wdata(bus_wdata[IRQ_N-1:0]), .stat_q(stat_q), .mask_q(mask_q),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_DAY:   rd_mux = DATA_W'(now_q.day);
      A_TLO:   rd_mux = DATA_W'(now_q.sod[LO_W-1:0]);
      A_THI:   rd_mux = DATA_W'(now_q.sod[SOD_W-1:LO_W]);
      A_ADAY:  rd_mux = DATA_W'(alm_q.day);
      A_ALO:   rd_mux = DATA_W'(alm_q.sod[LO_W-1:0]);
      A_AHI:   rd_mux = DATA_W'(alm_q.sod[SOD_W-1:LO_W]);
      A_STAT:  rd_mux = DATA_W'(stat_q);
      A_MASK:  rd_mux = DATA_W'(mask_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!mask_q[1]) |=> !irq_tick);
  assert_reset_irq_R12: assert property (@(posedge clk)
    rst |=> (!irq_alarm && !irq_tick && bus_rdata == '0));
endmodule

// File: tb/rtc_day_sec_core_tb.sv
module rtc_day_sec_core_tb;
  localparam int DIV = 8;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_alarm, irq_tick;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rtc_day_sec_core #(.PRESC_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic enables(int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_time(logic [15:0] day, logic [16:0] sod);
    wr(3'd1, 16'h0);
    wr(3'd0, day);
    wr(3'd2, 16'(sod[16:8]));
    wr(3'd1, 16'(sod[7:0]));
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R12 reset register", d, 16'h0);
    end
    check("R12 reset irq_alarm", 16'(irq_alarm), 16'h0);
    check("R12 reset irq_tick", 16'(irq_tick), 16'h0);
  endtask

  task automatic t_masks;
    logic [15:0] d;
    wr(3'd0, 16'hFFFF); rd(3'd0, d); check("R5 day mask", d, 16'h7FFF);
    wr(3'd1, 16'hFFFF); rd(3'd1, d); check("R5 low mask", d, 16'h00FF);
    wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R5 high mask", d, 16'h01FF);
    wr(3'd3, 16'hFFFF); rd(3'd3, d); check("R5 alarm day mask", d, 16'h7FFF);
    wr(3'd4, 16'hFFFF); rd(3'd4, d); check("R5 alarm low mask", d, 16'h00FF);
    wr(3'd5, 16'hFFFF); rd(3'd5, d); check("R5 alarm high mask", d, 16'h01FF);
    wr(3'd7, 16'hFFFF); rd(3'd7, d); check("R5 enable mask", d, 16'h0003);
    wr(3'd7, 16'h0); wr(3'd6, 16'h3);
  endtask

  task automatic t_restart;
    logic [15:0] d;
    enables(3);
    set_time(16'd1, 17'd5);
    enables(DIV - 1); rd(3'd1, d); check("R4 no tick before full period", d, 16'd5);
    enables(1);       rd(3'd1, d); check("R4 tick after full period", d, 16'd6);
  endtask

  task automatic t_day_end;
    logic [15:0] d;
    set_time(16'd3, 17'd86399);
    enables(DIV);
    rd(3'd1, d); check("R2 sod low after day end", d, 16'h0);
    rd(3'd2, d); check("R2 sod high after day end", d, 16'h0);
    rd(3'd0, d); check("R2 day increments", d, 16'd4);
    set_time(16'h7FFF, 17'd86399);
    enables(DIV);
    rd(3'd0, d); check("R3 day wraps", d, 16'h0);
  endtask

  task automatic t_carry;
    logic [15:0] d;
    set_time(16'd2, {9'h010, 8'hFF});
    enables(DIV);
    rd(3'd1, d); check("R6 low after carry", d, 16'h0);
    rd(3'd2, d); check("R6 high after carry", d, 16'h011);
    rd(3'd2, d); check("R1 high field is sod[16:8]", d, 16'h011);
  endtask

  task automatic t_low_zero;
    logic [15:0] d;
    set_time(16'd7, {9'h005, 8'h00});
    enables(255 * DIV);
    rd(3'd2, d); check("R7 high holds 255 ticks", d, 16'h005);
    rd(3'd1, d); check("R7 low after 255 ticks", d, 16'h0FF);
    enables(DIV);
    rd(3'd2, d); check("R7 high carries on tick 256", d, 16'h006);
  endtask

  task automatic t_update_irq;
    logic [15:0] d;
    wr(3'd6, 16'h3); wr(3'd7, 16'h0);
    enables(DIV);
    rd(3'd6, d); check("R8 update status set", d & 16'h2, 16'h2);
    check("R10 irq_tick gated off", 16'(irq_tick), 16'h0);
    wr(3'd7, 16'h2);
    @(negedge clk); check("R10 irq_tick asserted", 16'(irq_tick), 16'h1);
    wr(3'd6, 16'h2);
    @(negedge clk); check("R11 irq_tick cleared", 16'(irq_tick), 16'h0);
    rd(3'd6, d); check("R11 update bit cleared", d & 16'h2, 16'h0);
  endtask

  task automatic t_alarm;
    logic [15:0] d;
    wr(3'd3, 16'd4); wr(3'd4, 16'd10); wr(3'd5, 16'd0);
    set_time(16'd4, 17'd8);
    wr(3'd6, 16'h3); wr(3'd7, 16'h1);
    enables(DIV);
    rd(3'd6, d); check("R9 no alarm before match", d & 16'h1, 16'h0);
    enables(DIV);
    rd(3'd6, d); check("R9 alarm status on match", d, 16'h3);
    check("R10 irq_alarm asserted", 16'(irq_alarm), 16'h1);
    wr(3'd6, 16'h2);
    rd(3'd6, d); check("R11 written-0 bit kept", d, 16'h1);
    wr(3'd6, 16'h1);
    rd(3'd6, d); check("R11 alarm bit cleared", d, 16'h0);
    set_time(16'd5, 17'd9);
    enables(DIV);
    rd(3'd6, d); check("R9 no alarm on other day", d & 16'h1, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_restart();
    t_day_end();
    t_carry();
    t_low_zero();
    t_update_irq();
    t_alarm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule